// File: doc/BRIEF.md
# Bus Controller Command Sequencer

This block sits between a host register port and a simplified target-side bus interface. The host loads a handful of parameters (an own-ID setting, a destination ID, a LUN byte and a 24-bit transfer count) and then writes command bytes. The sequencer decodes each command and updates three things: an 8-bit bus status code, an 8-bit aux status flag byte and the transfer count. The aux byte holds interrupt (bit 7), busy (bit 5), command in progress (bit 4) and data buffer ready (bit 0). A select-and-transfer command starts a session with the chosen target. The target then reports its phase: execute, data-in, data-out or status.

In a data phase, bytes pass one at a time between the host streams and the target streams. Both directions use valid/ready handshakes and pass straight through with no buffering. A byte moves on a clock edge where valid and ready are both high. In the read direction, `hd_out_valid` follows `tgt_rx_valid`, and host back-pressure on `hd_out_ready` appears unchanged on `tgt_rx_ready`. In the write direction, `tgt_tx_valid` follows `hd_in_valid`, and `hd_in_ready` follows `tgt_tx_ready`. All of these pass only while the matching data phase is active. Every byte moved reduces both the transfer count and a per-block byte counter. When a block is used up, the target either reloads the block counter with a new length or ends the session with a zero length. At the end, the target's status byte is latched into the LUN register and the bus is released.

Top module: `cmd_sequencer`

## Requirements
- R1: After reset, aux status is 0x80, bus status is 0x00, and the transfer count and LUN register are zero.
- R2: A command byte written while aux bit 4 is set is ignored: bus status and target ID keep their values. Parameter writes are still accepted.
- R3: Command 0x00 clears the destination, LUN and transfer count. It sets bus status to 0x01 if the own-ID write had bit 3 set, and to 0x00 otherwise.
- R4: Command 0x04 issued with the bus free clears the transfer count and leaves bus status and aux status unchanged.
- R5: Commands 0x06 and 0x07 latch the target ID from destination bits [2:0], set bus status 0x42 and aux 0x80, and clear the transfer count.
- R6: Commands 0x08 and 0x09 fail when `tgt_busy` is high or the addressed bit of `tgt_sel_ok` is low. A failure gives status 0x42, aux 0x80, a cleared count and no `tgt_start`.
- R7: A successful 0x08 or 0x09 pulses `tgt_start` for one cycle. With 0x08, `tgt_msg_valid` pulses in the same cycle, carrying the LUN byte OR 0x80. With 0x09, no message is sent.
- R8: Aux reads 0x30 from the edge that accepts a successful select-and-transfer. On the next edge it becomes 0x31 if the target phase is data-in (1) or data-out (2), and stays 0x30 for execute (0). A later move from execute to a data phase sets 0x31.
- R9: Each byte moved through either stream lowers the transfer count by one, and the bytes arrive unchanged and in order.
- R10: When the block counter reaches zero, the sequencer waits for `tgt_blk_valid`. A nonzero `tgt_blk_count` starts another block in the same direction, and zero ends the session.
- R11: A session ends on a zero reload, or on the status phase (3) seen in execute or at start. At the end, LUN takes `tgt_status`, bus status becomes 0x16, aux becomes 0x80 and the count is cleared.
- R12: Command codes other than 0x00, 0x04 and 0x06–0x09 (for example 0x02 and 0x18) change no state.
- R13: A host write to a transfer count byte in the same cycle as a byte move yields the merged value minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Write target: 0 own-ID, 1 destination, 2 LUN, 3 count high, 4 count mid, 5 count low, 6 command |
| host_wdata | input | 8 | Host write byte |
| hd_in_valid | input | 1 | Host write-stream byte valid |
| hd_in_ready | output | 1 | Write-stream byte accepted |
| hd_in_data | input | 8 | Host write-stream byte |
| hd_out_valid | output | 1 | Read-stream byte valid |
| hd_out_ready | input | 1 | Host can take a read byte |
| hd_out_data | output | 8 | Read-stream byte |
| bus_status | output | 8 | Bus status code |
| aux_status | output | 8 | Aux flags: 7 interrupt, 5 busy, 4 command in progress, 0 buffer ready |
| xfer_count | output | 24 | Transfer count |
| lun_value | output | 8 | LUN register / latched target status |
| tgt_sel_ok | input | 8 | Per-ID selectable flags |
| tgt_busy | input | 1 | A device already holds the bus |
| tgt_start | output | 1 | Session start pulse |
| tgt_id | output | 3 | Latched target ID |
| tgt_msg_valid | output | 1 | Identify message pulse |
| tgt_msg_data | output | 8 | Identify message byte |
| tgt_phase | input | 2 | Target phase: 0 execute, 1 data-in, 2 data-out, 3 status |
| tgt_status | input | 8 | Target completion status |
| tgt_blk_count | input | 16 | Block length (sampled at phase entry and reload) |
| tgt_blk_valid | input | 1 | Reload length valid |
| tgt_rx_valid | input | 1 | Target read byte valid |
| tgt_rx_ready | output | 1 | Target read byte taken |
| tgt_rx_data | input | 8 | Target read byte |
| tgt_tx_valid | output | 1 | Write byte to target valid |
| tgt_tx_ready | input | 1 | Target takes write byte |
| tgt_tx_data | output | 8 | Write byte to target |

## Verification
A host write to a transfer-count byte and a byte move through a data stream can land on the same edge. The count then has two update sources in one cycle. The bench provokes this in a two-block read: the read stream is held stalled, then in a single cycle the stall is released and the low count byte is written. After that edge the count must equal the new low byte with the original upper bytes, minus one. A second overlap is a command arriving while a transfer is active. The bench issues a selection command in the data and execute phases and expects status and target ID to stay as they were.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  typedef enum logic [2:0] {
    SEL_OWN = 3'd0, SEL_DEST = 3'd1, SEL_LUN = 3'd2, SEL_TC_H = 3'd3,
    SEL_TC_M = 3'd4, SEL_TC_L = 3'd5, SEL_CMD = 3'd6, SEL_NONE = 3'd7
  } host_sel_e;

  typedef enum logic [1:0] {
    PH_EXEC = 2'd0, PH_DIN = 2'd1, PH_DOUT = 2'd2, PH_STAT = 2'd3
  } tgt_phase_e;

  typedef enum logic [2:0] {
    ST_FREE, ST_START, ST_EXEC, ST_DIN, ST_DOUT, ST_RELOAD
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_RESET, OP_DISC, OP_SELECT, OP_SEL_XFER
  } op_e;

  localparam logic [7:0] CMD_RESET    = 8'h00;
  localparam logic [7:0] CMD_DISC     = 8'h04;
  localparam logic [7:0] CMD_SEL_ATN  = 8'h06;
  localparam logic [7:0] CMD_SEL      = 8'h07;
  localparam logic [7:0] CMD_SELX_ATN = 8'h08;
  localparam logic [7:0] CMD_SELX     = 8'h09;

  localparam logic [7:0] STS_RESET     = 8'h00;
  localparam logic [7:0] STS_RESET_ADV = 8'h01;
  localparam logic [7:0] STS_XFER_END  = 8'h16;
  localparam logic [7:0] STS_SEL_TMO   = 8'h42;

  localparam int AUX_INT = 7;
  localparam int AUX_BSY = 5;
  localparam int AUX_CIP = 4;
  localparam int AUX_DBR = 0;

  localparam logic [7:0] AUX_IDLE = 8'h80;
  localparam logic [7:0] AUX_RUN  = 8'h30;
  localparam logic [7:0] AUX_DATA = 8'h31;

  localparam logic [7:0] IDENT_FLAG = 8'h80;
endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
  import cmdseq_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op,
  output logic       atn
);
  always_comb begin
    op  = OP_NONE;
    atn = 1'b0;
    case (code)
      CMD_RESET:    op = OP_RESET;
      CMD_DISC:     op = OP_DISC;
      CMD_SEL_ATN:  begin op = OP_SELECT; atn = 1'b1; end
      CMD_SEL:      op = OP_SELECT;
      CMD_SELX_ATN: begin op = OP_SEL_XFER; atn = 1'b1; end
      CMD_SELX:     op = OP_SEL_XFER;
      default:      op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/cmdseq_xfer_count.sv
module cmdseq_xfer_count #(
  parameter int W  = 24,
  localparam int NB = W / 8,
  localparam int LW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic          dec,
  output logic [W-1:0]  count
);
  logic [W-1:0] merged;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[b*8 +: 8] = (wr_en && wr_idx == LW'(b)) ? wr_byte : count[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else            count <= merged - W'(dec);
  end

  assert_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !wr_en && !clear) |=> count == W'($past(count) - 1'b1));

  assert_merge_dec_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && wr_en && !clear && wr_idx == '0)
      |=> count == W'({$past(count[W-1:8]), $past(wr_byte)} - 1'b1));
endmodule

// File: rtl/cmdseq_blk_count.sv
module cmdseq_blk_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (dec)  count <= count - 1'b1;
  end

  assign last = (count == W'(1));

  assert_blk_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> count != '0);
endmodule

// File: rtl/cmdseq_byte_route.sv
module cmdseq_byte_route #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din_en,
  input  logic          dout_en,
  input  logic          tgt_rx_valid,
  output logic          tgt_rx_ready,
  input  logic [DW-1:0] tgt_rx_data,
  output logic          hd_out_valid,
  input  logic          hd_out_ready,
  output logic [DW-1:0] hd_out_data,
  input  logic          hd_in_valid,
  output logic          hd_in_ready,
  input  logic [DW-1:0] hd_in_data,
  output logic          tgt_tx_valid,
  input  logic          tgt_tx_ready,
  output logic [DW-1:0] tgt_tx_data,
  output logic          moved
);
  assign hd_out_valid = din_en & tgt_rx_valid;
  assign tgt_rx_ready = din_en & hd_out_ready;
  assign hd_out_data  = tgt_rx_data;
  assign tgt_tx_valid = dout_en & hd_in_valid;
  assign hd_in_ready  = dout_en & tgt_tx_ready;
  assign tgt_tx_data  = hd_in_data;
  assign moved = (hd_out_valid & hd_out_ready) | (tgt_tx_valid & tgt_tx_ready);

  assert_one_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    moved |-> (din_en != dout_en));
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import cmdseq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int TC_W  = 24,
  parameter int BLK_W = 16,
  parameter int ID_W  = 3,
  localparam int NTGT = 1 << ID_W,
  localparam int NB   = TC_W / 8,
  localparam int LW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [2:0]       host_sel,
  input  logic [7:0]       host_wdata,
  input  logic             hd_in_valid,
  output logic             hd_in_ready,
  input  logic [DW-1:0]    hd_in_data,
  output logic             hd_out_valid,
  input  logic             hd_out_ready,
  output logic [DW-1:0]    hd_out_data,
  output logic [7:0]       bus_status,
  output logic [7:0]       aux_status,
  output logic [TC_W-1:0]  xfer_count,
  output logic [7:0]       lun_value,
  input  logic [NTGT-1:0]  tgt_sel_ok,
  input  logic             tgt_busy,
  output logic             tgt_start,
  output logic [ID_W-1:0]  tgt_id,
  output logic             tgt_msg_valid,
  output logic [7:0]       tgt_msg_data,
  input  logic [1:0]       tgt_phase,
  input  logic [7:0]       tgt_status,
  input  logic [BLK_W-1:0] tgt_blk_count,
  input  logic             tgt_blk_valid,
  input  logic             tgt_rx_valid,
  output logic             tgt_rx_ready,
  input  logic [DW-1:0]    tgt_rx_data,
  output logic             tgt_tx_valid,
  input  logic             tgt_tx_ready,
  output logic [DW-1:0]    tgt_tx_data
);
  localparam int OWN_ADV_BIT = 3;

  seq_state_e      st_q;
  logic            own_adv_q, dir_out_q, atn_q;
  logic [ID_W-1:0] dst_q, tid_q;
  logic [7:0]      lun_q, status_q, aux_q;

  host_sel_e  hsel;
  tgt_phase_e ph;
  op_e        op;
  logic       atn, cmd_we, cmd_go, sel_ok, finish, moved, blk_last;
  logic       blk_load, tc_clear, tc_we, data_ph;
  logic [LW-1:0] tc_lane;

  assign hsel    = host_sel_e'(host_sel);
  assign ph      = tgt_phase_e'(tgt_phase);
  assign cmd_we  = host_we && hsel == SEL_CMD;
  assign cmd_go  = cmd_we && !aux_q[AUX_CIP];
  assign sel_ok  = !tgt_busy && tgt_sel_ok[dst_q];
  assign data_ph = (ph == PH_DIN) || (ph == PH_DOUT);

  cmdseq_decode u_dec (.code(host_wdata), .op(op), .atn(atn));

  always_comb begin
    case (st_q)
      ST_START, ST_EXEC: finish = (ph == PH_STAT);
      ST_RELOAD:         finish = tgt_blk_valid && tgt_blk_count == '0;
      default:           finish = 1'b0;
    endcase
  end

  assign blk_load = ((st_q == ST_START || st_q == ST_EXEC) && data_ph) ||
                    (st_q == ST_RELOAD && tgt_blk_valid && tgt_blk_count != '0);

  assign tc_clear = finish ||
    (cmd_go && (op == OP_RESET || op == OP_DISC || op == OP_SELECT ||
                (op == OP_SEL_XFER && !sel_ok)));

  assign tc_we = host_we && (hsel == SEL_TC_H || hsel == SEL_TC_M || hsel == SEL_TC_L);

  always_comb begin
    case (hsel)
      SEL_TC_L: tc_lane = LW'(0);
      SEL_TC_M: tc_lane = LW'(1);
      default:  tc_lane = LW'(2);
    endcase
  end

  cmdseq_xfer_count #(.W(TC_W)) u_tc (
    .clk(clk), .rst_n(rst_n), .clear(tc_clear), .wr_en(tc_we),
    .wr_idx(tc_lane), .wr_byte(host_wdata), .dec(moved), .count(xfer_count)
  );

  cmdseq_blk_count #(.W(BLK_W)) u_blk (
    .clk(clk), .rst_n(rst_n), .load(blk_load), .load_val(tgt_blk_count),
    .dec(moved), .last(blk_last)
  );

  cmdseq_byte_route #(.DW(DW)) u_route (
    .clk(clk), .rst_n(rst_n),
    .din_en(st_q == ST_DIN), .dout_en(st_q == ST_DOUT),
    .tgt_rx_valid(tgt_rx_valid), .tgt_rx_ready(tgt_rx_ready), .tgt_rx_data(tgt_rx_data),
    .hd_out_valid(hd_out_valid), .hd_out_ready(hd_out_ready), .hd_out_data(hd_out_data),
    .hd_in_valid(hd_in_valid), .hd_in_ready(hd_in_ready), .hd_in_data(hd_in_data),
    .tgt_tx_valid(tgt_tx_valid), .tgt_tx_ready(tgt_tx_ready), .tgt_tx_data(tgt_tx_data),
    .moved(moved)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_FREE;
      own_adv_q <= 1'b0;
      dir_out_q <= 1'b0;
      atn_q     <= 1'b0;
      dst_q     <= '0;
      tid_q     <= '0;
      lun_q     <= '0;
      status_q  <= STS_RESET;
      aux_q     <= AUX_IDLE;
    end else begin
      if (host_we) begin
        case (hsel)
          SEL_OWN:  own_adv_q <= host_wdata[OWN_ADV_BIT];
          SEL_DEST: dst_q     <= host_wdata[ID_W-1:0];
          SEL_LUN:  lun_q     <= host_wdata;
          default:  ;
        endcase
      end
      if (cmd_go) begin
        case (op)
          OP_RESET: begin
            dst_q    <= '0;
            lun_q    <= '0;
            status_q <= own_adv_q ? STS_RESET_ADV : STS_RESET;
          end
          OP_SELECT: begin
            tid_q    <= dst_q;
            status_q <= STS_SEL_TMO;
            aux_q    <= AUX_IDLE;
          end
          OP_SEL_XFER: begin
            tid_q <= dst_q;
            atn_q <= atn;
            if (sel_ok) begin
              aux_q <= AUX_RUN;
              st_q  <= ST_START;
            end else begin
              status_q <= STS_SEL_TMO;
              aux_q    <= AUX_IDLE;
            end
          end
          default: ;
        endcase
      end
      case (st_q)
        ST_START, ST_EXEC: begin
          if (data_ph) begin
            aux_q     <= AUX_DATA;
            dir_out_q <= (ph == PH_DOUT);
            if (tgt_blk_count == '0) st_q <= ST_RELOAD;
            else st_q <= (ph == PH_DOUT) ? ST_DOUT : ST_DIN;
          end else if (ph == PH_EXEC) begin
            st_q <= ST_EXEC;
          end
        end
        ST_DIN, ST_DOUT: if (moved && blk_last) st_q <= ST_RELOAD;
        ST_RELOAD: if (tgt_blk_valid && tgt_blk_count != '0)
                     st_q <= dir_out_q ? ST_DOUT : ST_DIN;
        default: ;
      endcase
      if (finish) begin
        lun_q    <= tgt_status;
        status_q <= STS_XFER_END;
        aux_q    <= AUX_IDLE;
        st_q     <= ST_FREE;
      end
    end
  end

  assign bus_status    = status_q;
  assign aux_status    = aux_q;
  assign lun_value     = lun_q;
  assign tgt_id        = tid_q;
  assign tgt_start     = (st_q == ST_START);
  assign tgt_msg_valid = (st_q == ST_START) && atn_q;
  assign tgt_msg_data  = lun_q | IDENT_FLAG;

  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (aux_q == AUX_IDLE && status_q == STS_RESET && lun_q == '0));

  assert_cip_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && aux_q[AUX_CIP] && !finish) |=> ($stable(status_q) && $stable(tid_q)));

  assert_sel_tmo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_SELECT) |=> (status_q == STS_SEL_TMO && aux_q == AUX_IDLE));

  assert_selx_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_SEL_XFER && !sel_ok) |=> (status_q == STS_SEL_TMO && !tgt_start));

  assert_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_msg_valid |-> (tgt_start && tgt_msg_data[7]));

  assert_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (status_q == STS_XFER_END && aux_q == AUX_IDLE && xfer_count == '0));

  assert_unsup_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_NONE && st_q == ST_FREE) |=> ($stable(status_q) && $stable(aux_q)));
endmodule

// File: tb/cmd_sequencer_tb_top.sv
module cmd_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        host_we = 1'b0;
  logic [2:0]  host_sel = 3'd7;
  logic [7:0]  host_wdata = 8'h00;
  logic        hd_in_valid = 1'b0;
  logic        hd_in_ready;
  logic [7:0]  hd_in_data = 8'h00;
  logic        hd_out_valid;
  logic        hd_out_ready = 1'b0;
  logic [7:0]  hd_out_data;
  logic [7:0]  bus_status, aux_status, lun_value, tgt_msg_data;
  logic [23:0] xfer_count;
  logic [7:0]  tgt_sel_ok = 8'b0001_0010;
  logic        tgt_busy = 1'b0;
  logic        tgt_start, tgt_msg_valid;
  logic [2:0]  tgt_id;
  logic [1:0]  tm_phase = 2'd0;
  logic [7:0]  tm_status = 8'h00;
  logic [15:0] tgt_blk_count;
  logic        tgt_rx_ready, tgt_tx_valid;
  logic [7:0]  tgt_tx_data;
  logic [7:0]  rd_pat = 8'hA0;
  int          tm_moved = 0;
  int          tm_end = 0;
  localparam logic [15:0] BLK = 16'd4;

  assign tgt_blk_count = (tm_moved >= tm_end) ? 16'd0 : BLK;

  cmd_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .hd_in_valid(hd_in_valid), .hd_in_ready(hd_in_ready), .hd_in_data(hd_in_data),
    .hd_out_valid(hd_out_valid), .hd_out_ready(hd_out_ready), .hd_out_data(hd_out_data),
    .bus_status(bus_status), .aux_status(aux_status), .xfer_count(xfer_count),
    .lun_value(lun_value), .tgt_sel_ok(tgt_sel_ok), .tgt_busy(tgt_busy),
    .tgt_start(tgt_start), .tgt_id(tgt_id), .tgt_msg_valid(tgt_msg_valid),
    .tgt_msg_data(tgt_msg_data), .tgt_phase(tm_phase), .tgt_status(tm_status),
    .tgt_blk_count(tgt_blk_count), .tgt_blk_valid(1'b1),
    .tgt_rx_valid(1'b1), .tgt_rx_ready(tgt_rx_ready), .tgt_rx_data(rd_pat),
    .tgt_tx_valid(tgt_tx_valid), .tgt_tx_ready(1'b1), .tgt_tx_data(tgt_tx_data)
  );

  // behavioural target: advances its byte pattern and move count on each handshake
  always @(posedge clk) begin
    if (tgt_rx_ready) begin
      rd_pat   <= rd_pat + 8'd1;
      tm_moved <= tm_moved + 1;
    end else if (tgt_tx_valid) begin
      tm_moved <= tm_moved + 1;
    end
  end

  int n_total = 0, n_fail = 0;
  int start_cnt = 0, msg_cnt = 0, rd_popped = 0, wr_popped = 0;
  logic [7:0] last_msg = 8'h00;
  logic [7:0] rd_q[$];
  logic [7:0] wr_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: samples one ns before each rising edge
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (tgt_start) start_cnt++;
      if (tgt_msg_valid) begin msg_cnt++; last_msg = tgt_msg_data; end
      if (hd_out_valid && hd_out_ready) begin
        if (rd_q.size() == 0) chk("R9 unexpected read byte", 1, 0);
        else chk("R9 read byte", hd_out_data, rd_q.pop_front());
        rd_popped++;
      end
      if (tgt_tx_valid) begin
        if (wr_q.size() == 0) chk("R9 unexpected write byte", 1, 0);
        else chk("R9 write byte", tgt_tx_data, wr_q.pop_front());
        wr_popped++;
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic host_write(logic [2:0] sel, logic [7:0] val);
    @(negedge clk);
    #1;
    host_we = 1'b1; host_sel = sel; host_wdata = val;
    tick();
    host_we = 1'b0; host_sel = 3'd7;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100; k++) begin
      if (aux_status == 8'h80) break;
      tick();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 aux", aux_status, 8'h80);
    chk("R1 status", bus_status, 8'h00);
    chk("R1 count", xfer_count, 0);
    chk("R1 lun", lun_value, 0);

    // R3: reset command with advanced bit set
    host_write(3'd0, 8'h08);
    host_write(3'd1, 8'h05);
    host_write(3'd2, 8'h33);
    host_write(3'd3, 8'h01);
    host_write(3'd6, 8'h00);
    chk("R3 status adv", bus_status, 8'h01);
    chk("R3 count", xfer_count, 0);
    chk("R3 lun", lun_value, 0);
    host_write(3'd6, 8'h07);
    chk("R3 dest cleared", tgt_id, 3'd0);
    host_write(3'd0, 8'h00);
    host_write(3'd6, 8'h00);
    chk("R3 status plain", bus_status, 8'h00);

    // R5: select without transfer
    host_write(3'd1, 8'h03);
    host_write(3'd5, 8'h55);
    host_write(3'd6, 8'h06);
    chk("R5 target id", tgt_id, 3'd3);
    chk("R5 status", bus_status, 8'h42);
    chk("R5 aux", aux_status, 8'h80);
    chk("R5 count", xfer_count, 0);

    // R12: unsupported codes
    host_write(3'd4, 8'h01);
    host_write(3'd5, 8'h23);
    host_write(3'd6, 8'h18);
    chk("R12 count kept", xfer_count, 24'h000123);
    chk("R12 status kept", bus_status, 8'h42);
    host_write(3'd6, 8'h02);
    chk("R12 aux kept", aux_status, 8'h80);
    chk("R12 count kept 02", xfer_count, 24'h000123);

    // R4: disconnect with the bus free
    host_write(3'd6, 8'h04);
    chk("R4 count", xfer_count, 0);
    chk("R4 status", bus_status, 8'h42);
    chk("R4 aux", aux_status, 8'h80);

    // R6: select-transfer timeouts
    host_write(3'd6, 8'h00);
    host_write(3'd1, 8'h02);
    host_write(3'd6, 8'h09);
    chk("R6 unselectable status", bus_status, 8'h42);
    chk("R6 unselectable id", tgt_id, 3'd2);
    host_write(3'd6, 8'h00);
    host_write(3'd1, 8'h04);
    tgt_busy = 1'b1;
    host_write(3'd6, 8'h09);
    tgt_busy = 1'b0;
    chk("R6 busy status", bus_status, 8'h42);
    chk("R6 busy aux", aux_status, 8'h80);
    tick();
    chk("R6 no start", start_cnt, 0);

    // two-block read with identify message
    host_write(3'd6, 8'h00);
    host_write(3'd1, 8'h04);
    host_write(3'd2, 8'h05);
    host_write(3'd5, 8'h08);
    tm_phase = 2'd1; tm_status = 8'h02; tm_end = tm_moved + 8;
    for (int i = 0; i < 8; i++) rd_q.push_back(rd_pat + 8'(i));
    host_write(3'd6, 8'h08);
    chk("R8 aux at accept", aux_status, 8'h30);
    tick();
    chk("R8 aux data-in", aux_status, 8'h31);
    chk("R7 start pulses", start_cnt, 1);
    chk("R7 identify count", msg_cnt, 1);
    chk("R7 identify byte", last_msg, 8'h85);
    host_write(3'd1, 8'h06);
    host_write(3'd6, 8'h06);
    chk("R2 status kept", bus_status, 8'h00);
    chk("R2 id kept", tgt_id, 3'd4);
    // R13: count byte write on the same edge as a byte move
    hd_out_ready = 1'b1;
    host_we = 1'b1; host_sel = 3'd5; host_wdata = 8'h40;
    tick();
    host_we = 1'b0; host_sel = 3'd7; hd_out_ready = 1'b0;
    chk("R13 merged minus one", xfer_count, 24'h00003F);
    chk("R13 one byte moved", rd_popped, 1);
    hd_out_ready = 1'b1;
    wait_idle();
    hd_out_ready = 1'b0;
    chk("R10 both blocks read", rd_popped, 8);
    chk("R11 read status", bus_status, 8'h16);
    chk("R11 read lun", lun_value, 8'h02);
    chk("R11 read count", xfer_count, 0);

    // single-block write via execute phase, no attention
    host_write(3'd6, 8'h00);
    host_write(3'd1, 8'h01);
    host_write(3'd5, 8'h10);
    tm_phase = 2'd0; tm_status = 8'h08; tm_end = tm_moved + 4;
    host_write(3'd6, 8'h09);
    tick();
    chk("R8 aux execute", aux_status, 8'h30);
    chk("R7 no identify", msg_cnt, 1);
    host_write(3'd6, 8'h06);
    chk("R2 execute status kept", bus_status, 8'h00);
    tm_phase = 2'd2;
    tick();
    chk("R8 aux data-out", aux_status, 8'h31);
    for (int i = 0; i < 4; i++) begin
      hd_in_valid = 1'b1;
      hd_in_data = 8'h11 * 8'(i + 1);
      wr_q.push_back(hd_in_data);
      tick();
      if (i == 0) chk("R9 count decrement", xfer_count, 24'h00000F);
    end
    hd_in_valid = 1'b0;
    wait_idle();
    chk("R10 write bytes", wr_popped, 4);
    chk("R11 write status", bus_status, 8'h16);
    chk("R11 write lun", lun_value, 8'h08);

    // status phase straight after start
    host_write(3'd6, 8'h00);
    host_write(3'd1, 8'h04);
    tm_phase = 2'd3; tm_status = 8'h7E;
    host_write(3'd6, 8'h09);
    tick();
    chk("R11 direct status", bus_status, 8'h16);
    chk("R11 direct lun", lun_value, 8'h7E);
    chk("R11 direct aux", aux_status, 8'h80);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule